// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block times each programmed I/O access on a two-channel parallel ATA bus. It has four drive slots. Drives 0 and 1 are on the primary channel, and drives 2 and 3 are on the secondary channel. When the host raises a request for a drive, the engine runs through three phases in order:

1. It holds the address-setup time with the strobe off.
2. It asserts the read strobe or the write strobe for the active count.
3. It keeps the strobe off for the recovery count.

It accepts no new request until all three phases are over.

Every drive slot has one timing byte. The high nibble holds the active count and the low nibble holds the recovery code. Both codes are nonlinear, and a code of zero selects the longest time. Each primary drive has its own 2-bit setup field, and the hardware applies the longer of the two primary fields to any primary cycle. Both secondary drives share one setup register. That register also holds two read-ahead disable bits and a secondary-channel interrupt flag that is cleared by writing a one. Software loads all fields through a byte-wide register port. At the nominal 33 MHz timing clock, one count is about 30 ns.

Top module: `ata_pio_timer`

## Requirements
- R1: The active count is the high nibble n of the selected drive's timing byte. Values 1..15 give n clocks of strobe and 0 gives 16 clocks.
- R2: The recovery code is the low nibble c of the timing byte. Code 0 gives 16 clocks, codes 1..14 give c+1 clocks, and code 15 gives 1 clock.
- R3: A setup field is bits 7:6 of its register. 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R4: A primary-channel cycle (drive 0 or 1) uses the longer of the setup fields at address 4 (drive 0) and address 5 (drive 1).
- R5: Both secondary drives (2 and 3) use the single setup field at address 6.
- R6: After a request is accepted, busy_o is high for setup + active + recovery clocks. The strobe is high only during the active phase. A read request uses rd_strobe_o and a write request uses wr_strobe_o, and the two are never high together.
- R7: The engine ignores a request while busy_o is high, and drive or direction changes during a cycle do not affect it. A request that is still held when the cycle ends is accepted after one idle clock.
- R8: After reset, every timing byte reads 0x00, which is active 16 and recovery 16. Addresses 4, 5 and 6 read 0xC0, which is setup 5 with the interrupt flag and read-ahead bits clear.
- R9: A high on sec_irq_i sets bit 4 of address 6. Writing a 1 to that bit clears the flag and writing a 0 leaves it unchanged. A set on the same clock as a clear wins.
- R10: Timing bytes sit at addresses 0..3, one per drive, and read back as written. Address 6 keeps bits 7:6 and the read-ahead bits 3:2 as written. Addresses 4 and 5 keep only bits 7:6, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data, combinational from the address |
| sec_irq_i | input | 1 | Secondary-channel interrupt event |
| req_i | input | 1 | Cycle request, level |
| req_drive_i | input | 2 | Drive for the request |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| busy_o | output | 1 | Cycle in progress |
| rd_strobe_o | output | 1 | Read strobe, active high |
| wr_strobe_o | output | 1 | Write strobe, active high |

## Verification
The assertions check the following on every cycle:

- A strobe is never high outside busy_o.
- The two strobes never overlap.
- Every strobe is followed by at least one recovery clock.
- busy_o only rises after a request.
- The interrupt flag is visible the clock after an event.

The exact phase lengths for every active, recovery and setup encoding, the slower-of-two choice on the primary channel, and the hold of a request across a busy cycle depend on the register contents. Only the bench's sweeps show these, by measuring the strobe widths at the ports.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned NUM_DRIVES = 4;
  localparam int unsigned DRV_W      = $clog2(NUM_DRIVES);
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned CNT_W      = 4;
  localparam int unsigned SU_W       = 3;

  localparam logic [ADDR_W-1:0] ADDR_SU_D0  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SU_D1  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_SU_SEC = 3'd6;
  localparam int unsigned IRQ_BIT = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_e;

  // counts are held as length-1
  function automatic logic [CNT_W-1:0] act_m1(input logic [3:0] n);
    return (n == 4'd0) ? 4'hF : n - 4'd1;
  endfunction

  function automatic logic [CNT_W-1:0] rec_m1(input logic [3:0] c);
    if (c == 4'd0)      return 4'hF;
    else if (c == 4'hF) return 4'h0;
    else                return c;
  endfunction

  function automatic logic [SU_W-1:0] setup_clks(input logic [1:0] f);
    case (f)
      2'b01:   return 3'd2;
      2'b10:   return 3'd3;
      2'b00:   return 3'd4;
      default: return 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
  import ata_pio_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [7:0]                      wdata_i,
  input  logic                            sec_irq_i,
  output logic [7:0]                      rdata_o,
  output logic [NUM_DRIVES-1:0][7:0]      tim_o,
  output logic [2:0][1:0]                 su_o
);
  logic [NUM_DRIVES-1:0][7:0] tim_q;
  logic [2:0][1:0]            su_q;
  logic [1:0]                 ra_q;
  logic                       irq_q;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  tim_q[g] <= 8'h00;
      else if (we_i && addr_i == ADDR_W'(g))        tim_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      su_q  <= {3{2'b11}};
      ra_q  <= 2'b00;
      irq_q <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          ADDR_SU_D0:  su_q[0] <= wdata_i[7:6];
          ADDR_SU_D1:  su_q[1] <= wdata_i[7:6];
          ADDR_SU_SEC: begin
            su_q[2] <= wdata_i[7:6];
            ra_q    <= wdata_i[3:2];
          end
          default: ;
        endcase
      end
      if (sec_irq_i)
        irq_q <= 1'b1;
      else if (we_i && addr_i == ADDR_SU_SEC && wdata_i[IRQ_BIT])
        irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_SU_D0:  rdata_o = {su_q[0], 6'b0};
      ADDR_SU_D1:  rdata_o = {su_q[1], 6'b0};
      ADDR_SU_SEC: rdata_o = {su_q[2], 1'b0, irq_q, ra_q, 2'b0};
      default: if (int'(addr_i) < NUM_DRIVES) rdata_o = tim_q[DRV_W'(addr_i)];
    endcase
  end

  assign tim_o = tim_q;
  assign su_o  = su_q;
endmodule

// File: rtl/ata_pio_setup_sel.sv
module ata_pio_setup_sel
  import ata_pio_pkg::*;
(
  input  logic [2:0][1:0]   su_i,
  input  logic [DRV_W-1:0]  drive_i,
  output logic [CNT_W-1:0]  setup_m1_o
);
  logic [SU_W-1:0] s0, s1, sh, pri, sel;

  assign s0  = setup_clks(su_i[0]);
  assign s1  = setup_clks(su_i[1]);
  assign sh  = setup_clks(su_i[2]);
  assign pri = (s0 > s1) ? s0 : s1;   // slower primary drive wins
  assign sel = drive_i[DRV_W-1] ? sh : pri;
  assign setup_m1_o = CNT_W'(sel - 3'd1);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [DRV_W-1:0]            drive_i,
  input  logic                        write_i,
  input  logic [NUM_DRIVES-1:0][7:0]  tim_i,
  input  logic [CNT_W-1:0]            setup_m1_i,
  output logic                        busy_o,
  output logic                        rd_o,
  output logic                        wr_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, act_q, rec_q;
  logic             wr_q;
  logic [7:0]       sel_tim;

  assign sel_tim = tim_i[drive_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      act_q <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= setup_m1_i;
          act_q <= act_m1(sel_tim[7:4]);
          rec_q <= rec_m1(sel_tim[3:0]);
          wr_q  <= write_i;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_ACT;
          cnt_q <= act_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACT: if (cnt_q == '0) begin
          ph_q  <= PH_REC;
          cnt_q <= rec_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_REC: if (cnt_q == '0) ph_q <= PH_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign rd_o   = (ph_q == PH_ACT) && !wr_q;
  assign wr_o   = (ph_q == PH_ACT) &&  wr_q;
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              sec_irq_i,
  input  logic              req_i,
  input  logic [DRV_W-1:0]  req_drive_i,
  input  logic              req_write_i,
  output logic              busy_o,
  output logic              rd_strobe_o,
  output logic              wr_strobe_o
);
  logic [NUM_DRIVES-1:0][7:0] tim;
  logic [2:0][1:0]            su;
  logic [CNT_W-1:0]           setup_m1;

  ata_pio_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .sec_irq_i, .rdata_o(cfg_rdata_o), .tim_o(tim), .su_o(su)
  );

  ata_pio_setup_sel u_sel (
    .su_i(su), .drive_i(req_drive_i), .setup_m1_o(setup_m1)
  );

  ata_pio_seq u_seq (
    .clk_i, .rst_ni,
    .req_i, .drive_i(req_drive_i), .write_i(req_write_i),
    .tim_i(tim), .setup_m1_i(setup_m1),
    .busy_o, .rd_o(rd_strobe_o), .wr_o(wr_strobe_o)
  );
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk
  import ata_pio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              rd_strobe_o,
  input logic              wr_strobe_o,
  input logic              sec_irq_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [7:0]        cfg_rdata_o
);
  assert_one_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_o && wr_strobe_o));
  assert_strobe_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_o || wr_strobe_o) |-> busy_o);
  assert_recovery_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_strobe_o) || $fell(wr_strobe_o)) |-> busy_o);
  assert_start_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  assert_irq_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sec_irq_i) && cfg_addr_i == ADDR_SU_SEC) |-> cfg_rdata_o[IRQ_BIT]);
endmodule

bind ata_pio_timer ata_pio_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o),
  .sec_irq_i(sec_irq_i), .cfg_addr_i(cfg_addr_i), .cfg_rdata_o(cfg_rdata_o)
);

// File: tb/ata_pio_timer_tb.sv
`timescale 1ns/1ps
module ata_pio_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq = 1'b0;
  logic       req = 1'b0;
  logic [1:0] drv = '0;
  logic       wrdir = 1'b0;
  logic       busy, rd, wr;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ata_pio_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .sec_irq_i(irq),
    .req_i(req), .req_drive_i(drv), .req_write_i(wrdir),
    .busy_o(busy), .rd_strobe_o(rd), .wr_strobe_o(wr)
  );

  function automatic int e_act(int n);  return (n == 0) ? 16 : n; endfunction
  function automatic int e_rec(int c);
    return (c == 0) ? 16 : (c == 15) ? 1 : c + 1;
  endfunction
  function automatic int e_su(int f);
    case (f) 1: return 2; 2: return 3; 0: return 4; default: return 5; endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wreg(int a, int d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rreg(int a, output int d);
    @(negedge clk); addr = 3'(a); #1 d = int'(rdata);
  endtask

  task automatic measure(output int s, output int a, output int r,
                         output int rs, output int ws);
    s = 0; a = 0; r = 0; rs = 0; ws = 0;
    while (busy && !(rd || wr)) begin s++; @(negedge clk); end
    while (rd || wr) begin
      a++; if (rd) rs = 1; if (wr) ws = 1; @(negedge clk);
    end
    while (busy && !(rd || wr)) begin r++; @(negedge clk); end
  endtask

  task automatic run(int d, int w, output int s, output int a, output int r,
                     output int rs, output int ws);
    @(negedge clk); req = 1'b1; drv = 2'(d); wrdir = w[0];
    @(negedge clk); req = 1'b0;
    measure(s, a, r, rs, ws);
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, a, r, rs, ws, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset contents and slowest cycle
    for (int i = 0; i < 4; i++) begin rreg(i, d); chk("R8 tim reset", d, 0); end
    for (int i = 4; i < 7; i++) begin rreg(i, d); chk("R8 setup reset", d, 8'hC0); end
    run(0, 0, s, a, r, rs, ws);
    chk("R8 setup 5", s, 5); chk("R8 active 16", a, 16); chk("R8 recovery 16", r, 16);
    chk("R6 read strobe", rs, 1); chk("R6 no write strobe", ws, 0);

    // R1 R2 active and recovery sweep on drive 2
    for (int i = 0; i < 16; i++) begin
      wreg(2, (i << 4) | (15 - i));
      rreg(2, d); chk("R10 tim readback", d, (i << 4) | (15 - i));
      run(2, 0, s, a, r, rs, ws);
      chk("R1 active", a, e_act(i));
      chk("R2 recovery", r, e_rec(15 - i));
    end

    // R3 R5 shared secondary setup
    for (int f = 0; f < 4; f++) begin
      wreg(6, f << 6);
      run(3, 1, s, a, r, rs, ws);
      chk("R3 R5 setup drive3", s, e_su(f));
      chk("R6 write strobe", ws, 1); chk("R6 no read strobe", rs, 0);
      run(2, 0, s, a, r, rs, ws);
      chk("R5 setup drive2", s, e_su(f));
    end

    // R4 primary slower-of-two
    for (int f0 = 0; f0 < 4; f0++)
      for (int f1 = 0; f1 < 4; f1++) begin
        wreg(4, (f0 << 6) | 8'h3F);
        wreg(5, f1 << 6);
        rreg(4, d); chk("R10 su0 readback", d, f0 << 6);
        run((f0 + f1) % 2, 0, s, a, r, rs, ws);
        chk("R4 primary setup", s, (e_su(f0) > e_su(f1)) ? e_su(f0) : e_su(f1));
      end

    // R7 request held across busy, changes ignored mid-cycle
    wreg(2, 8'h21); wreg(3, 8'h35); wreg(6, 8'h40);
    @(negedge clk); req = 1'b1; drv = 2'd2; wrdir = 1'b0;
    @(negedge clk); drv = 2'd3; wrdir = 1'b1;
    measure(s, a, r, rs, ws);
    chk("R7 first setup", s, 2); chk("R7 first active", a, 2);
    chk("R7 first recovery", r, 2); chk("R7 first is read", rs, 1);
    chk("R7 idle gap", int'(busy), 0);
    @(negedge clk);
    req = 1'b0;
    measure(s, a, r, rs, ws);
    chk("R7 second active", a, 3); chk("R7 second recovery", r, 6);
    chk("R7 second is write", ws, 1);

    // R9 R10 interrupt flag and read-ahead bits
    rreg(6, d); chk("R9 flag clear", (d >> 4) & 1, 0);
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    rreg(6, d); chk("R9 flag set", (d >> 4) & 1, 1);
    wreg(6, 8'hCC);
    rreg(6, d); chk("R9 write 0 keeps flag", d, 8'hDC);
    wreg(6, 8'h90);
    rreg(6, d); chk("R9 write 1 clears flag", d, 8'h80);
    rreg(5, d); chk("R10 su1 readback", d, 8'hC0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule